// File: doc/BRIEF.md
# Two-Level Interrupt Routing Register Bank

This block holds the software-visible state of a 51-line interrupt controller and turns it into two processor interrupt outputs: a normal request and a fast request. Each line has an enable bit and a routing bit. The routing bit picks which of the two outputs the line drives. A per-line pending vector is kept inside the block and fed by an external trigger-capture stage. That stage supplies two inputs: a per-line asserted level, used for level-sensitive lines, and one-cycle event pulses, used for edge-sensitive lines. The configuration vectors the capture stage needs (sensitivity, both-edge, event polarity) are driven out as ports.

Every 51-bit vector is seen by software as two words. The low word holds lines 31..0. The high word holds lines 50..32 in its bits 18:0. Register accesses use a simple one-cycle request bus. Two address windows decode to the same state. The upper window, at offsets 0x80 and above, reaches both words: address bit 2 picks the high word. The lower window, below 0x80, reaches only low words. The bus has no back-pressure: a request is accepted on every cycle its valid is high. Read data comes back on the following cycle with a one-cycle response strobe, and the requester must take it then.

Top module: `dpic_regbank`

## Requirements
- R1: After reset, sensitivity = 0x1F07FFF8FFFF, both-edge = 0x00F800070000 and event = 0x5F07FFF8FFFF. Enable, routing and pending are zero, and both interrupt outputs are low.
- R2: For addresses at or above 0x80, bit 2 selects the high word, which carries lines 50..32 in bits 18:0. Written data is masked to those 19 bits, and reads return zeros in bits 31:19. Addresses below 0x80 reach low words only. Legacy offsets: 0x00 normal status, 0x04 fast status, 0x08 pending, 0x0C routing, 0x10 enable-set, 0x14 enable-clear, 0x18 software, 0x1C software-clear, 0x24 sensitivity, 0x28 both-edge, 0x2C event, 0x38 edge-clear.
- R3: A write to enable-set (0xA0/0xA4, legacy 0x10) ORs the written bits into enable. A write to enable-clear (0xA8/0xAC, legacy 0x14) clears the written bits. Reading 0xA0/0xA4 returns enable.
- R4: A write to routing (0x98/0x9C, legacy 0x0C) replaces only the addressed word and leaves the other word unchanged. A routing bit of 1 sends the line to the fast output.
- R5: Normal status (0x80) reads pending & enable & ~routing. Fast status (0x88) reads pending & enable & routing. Pending (0x90) reads the pending vector. Edge status (0xE0) reads pending & ~sensitivity.
- R6: A write to edge-clear (0xD8/0xDC, legacy 0x38) clears pending bits only on edge-sensitive lines (sensitivity bit 0). Level-sensitive pending bits are unaffected.
- R7: The event vector changes only on a write to 0xD4, and only in bits 18:15 of that word (lines 50..47). Writes to 0xD0 and to legacy 0x2C are ignored.
- R8: Reads of enable-clear, software-clear, edge-clear, the software register and unmapped addresses (including any with bits 1:0 non-zero) return zero. Writes to status, pending, sensitivity, both-edge, the software registers and unmapped addresses change nothing.
- R9: The fast output is the OR of pending & enable & routing. The normal output is the OR of pending & enable & ~routing. Both are registered and follow a state change one clock later.
- R10: A level-sensitive pending bit takes the value of its capture level input on every clock. An edge-sensitive pending bit is set by a capture pulse and holds until cleared. A pulse in the same cycle as a clear of that line wins.
- R11: Every read request gives exactly one response strobe, together with its data, on the next cycle. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with resp_valid |
| resp_valid | output | 1 | Read response strobe, one cycle after the read |
| cap_level | input | 51 | Per-line asserted level from the capture stage |
| cap_set | input | 51 | Per-line one-cycle edge event pulses |
| cfg_sense | output | 51 | Sensitivity vector, 1 = level |
| cfg_both | output | 51 | Both-edge vector |
| cfg_event | output | 51 | Event polarity vector |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Read data is due on the clock edge after the edge that takes the request. Expected words are therefore queued when the read is driven, and a monitor pops them on the falling edge that follows the response strobe. Pending, enable and routing change on the edge that takes a write or capture input, and the outputs register one edge later. Output checks are therefore made on the second falling edge after the stimulus, and a check on the first falling edge confirms the old value still holds. Each ignored write is followed by a read of the state it could have changed.

// File: rtl/dpic_pkg.sv
package dpic_pkg;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_IRQ_ST,
    RG_FIQ_ST,
    RG_RAW,
    RG_SEL,
    RG_EN_SET,
    RG_EN_CLR,
    RG_SWI,
    RG_SWI_CLR,
    RG_SENSE,
    RG_BOTH,
    RG_EVENT,
    RG_EDGE_CLR,
    RG_EDGE_ST
  } dpic_reg_e;

  typedef struct packed {
    dpic_reg_e id;
    logic      hi;      // high word of the 51-bit vector
    logic      evt_wr;  // event register reachable for writing
  } dpic_dec_t;

endpackage

// File: rtl/dpic_decode.sv
module dpic_decode
  import dpic_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NEW_BASE = 128
) (
  input  logic [ADDR_W-1:0] addr,
  output dpic_dec_t         dec
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(NEW_BASE);

  logic              newwin;
  logic [ADDR_W-1:0] rel;

  always_comb begin
    newwin     = (addr >= BASE);
    rel        = newwin ? ((addr & ~ADDR_W'(4)) - BASE) : addr;
    dec.hi     = newwin & addr[2];
    dec.evt_wr = 1'b0;
    dec.id     = RG_NONE;
    if (newwin) begin
      case (rel)
        ADDR_W'('h00): dec.id = RG_IRQ_ST;
        ADDR_W'('h08): dec.id = RG_FIQ_ST;
        ADDR_W'('h10): dec.id = RG_RAW;
        ADDR_W'('h18): dec.id = RG_SEL;
        ADDR_W'('h20): dec.id = RG_EN_SET;
        ADDR_W'('h28): dec.id = RG_EN_CLR;
        ADDR_W'('h30): dec.id = RG_SWI;
        ADDR_W'('h38): dec.id = RG_SWI_CLR;
        ADDR_W'('h40): dec.id = RG_SENSE;
        ADDR_W'('h48): dec.id = RG_BOTH;
        ADDR_W'('h50): begin
          dec.id     = RG_EVENT;
          dec.evt_wr = 1'b1;
        end
        ADDR_W'('h58): dec.id = RG_EDGE_CLR;
        ADDR_W'('h60): dec.id = RG_EDGE_ST;
        default:       dec.id = RG_NONE;
      endcase
    end else begin
      case (rel)
        ADDR_W'('h00): dec.id = RG_IRQ_ST;
        ADDR_W'('h04): dec.id = RG_FIQ_ST;
        ADDR_W'('h08): dec.id = RG_RAW;
        ADDR_W'('h0C): dec.id = RG_SEL;
        ADDR_W'('h10): dec.id = RG_EN_SET;
        ADDR_W'('h14): dec.id = RG_EN_CLR;
        ADDR_W'('h18): dec.id = RG_SWI;
        ADDR_W'('h1C): dec.id = RG_SWI_CLR;
        ADDR_W'('h24): dec.id = RG_SENSE;
        ADDR_W'('h28): dec.id = RG_BOTH;
        ADDR_W'('h2C): dec.id = RG_EVENT;     // readable, never written here
        ADDR_W'('h38): dec.id = RG_EDGE_CLR;
        default:       dec.id = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dpic_state.sv
module dpic_state
  import dpic_pkg::*;
#(
  parameter int                NLINES  = 51,
  parameter int                EVT_LO  = 47,
  parameter int                EVT_W   = 4,
  parameter logic [NLINES-1:0] EVT_RST = NLINES'(64'h5F07FFF8FFFF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  dpic_dec_t         dec,
  input  logic [31:0]       wdata,
  input  logic [NLINES-1:0] sense,
  input  logic [NLINES-1:0] cap_level,
  input  logic [NLINES-1:0] cap_set,
  output logic [NLINES-1:0] raw_q,
  output logic [NLINES-1:0] en_q,
  output logic [NLINES-1:0] sel_q,
  output logic [NLINES-1:0] evt_q
);

  localparam int                HI_W     = NLINES - 32;
  localparam logic [NLINES-1:0] LO_MASK  = {{HI_W{1'b0}}, {32{1'b1}}};
  localparam logic [NLINES-1:0] HI_MASK  = ~LO_MASK;
  localparam logic [NLINES-1:0] EVT_MASK = ((NLINES'(1) << EVT_W) - NLINES'(1)) << EVT_LO;

  logic [NLINES-1:0] wvec, hmask, edge_clr, raw_d;
  logic              wr_sel, wr_set, wr_clr, wr_eclr, wr_evt;

  always_comb begin
    // place the written word at its half; high half keeps HI_W bits only
    wvec  = dec.hi ? {wdata[HI_W-1:0], 32'b0} : {{HI_W{1'b0}}, wdata};
    hmask = dec.hi ? HI_MASK : LO_MASK;

    wr_sel  = wr_en && (dec.id == RG_SEL);
    wr_set  = wr_en && (dec.id == RG_EN_SET);
    wr_clr  = wr_en && (dec.id == RG_EN_CLR);
    wr_eclr = wr_en && (dec.id == RG_EDGE_CLR);
    wr_evt  = wr_en && (dec.id == RG_EVENT) && dec.hi && dec.evt_wr;

    edge_clr = wr_eclr ? (wvec & ~sense) : '0;
    // level lines follow their input; edge lines latch, pulse beats clear
    raw_d = (sense & cap_level) | (~sense & ((raw_q & ~edge_clr) | cap_set));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
      sel_q <= '0;
      evt_q <= EVT_RST;
    end else begin
      raw_q <= raw_d;
      if (wr_sel) sel_q <= (sel_q & ~hmask) | wvec;
      if (wr_set)      en_q <= en_q | wvec;
      else if (wr_clr) en_q <= en_q & ~wvec;
      if (wr_evt) evt_q <= (evt_q & ~EVT_MASK) | (wvec & EVT_MASK);
    end
  end

endmodule

// File: rtl/dpic_out.sv
module dpic_out
  import dpic_pkg::*;
#(
  parameter int NLINES = 51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  dpic_dec_t         dec,
  input  logic [NLINES-1:0] raw,
  input  logic [NLINES-1:0] en,
  input  logic [NLINES-1:0] sel,
  input  logic [NLINES-1:0] sense,
  input  logic [NLINES-1:0] both,
  input  logic [NLINES-1:0] evt,
  output logic [31:0]       rdata,
  output logic              resp_valid,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam int HI_W = NLINES - 32;

  logic [NLINES-1:0] val, act;
  logic [31:0]       word;

  always_comb begin
    act = raw & en;
    case (dec.id)
      RG_IRQ_ST:  val = act & ~sel;
      RG_FIQ_ST:  val = act & sel;
      RG_RAW:     val = raw;
      RG_SEL:     val = sel;
      RG_EN_SET:  val = en;
      RG_SENSE:   val = sense;
      RG_BOTH:    val = both;
      RG_EVENT:   val = evt;
      RG_EDGE_ST: val = raw & ~sense;
      default:    val = '0;
    endcase
    word = dec.hi ? {{(32-HI_W){1'b0}}, val[NLINES-1:32]} : val[31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata      <= '0;
      resp_valid <= 1'b0;
      irq_o      <= 1'b0;
      fiq_o      <= 1'b0;
    end else begin
      resp_valid <= rd_en;
      if (rd_en) rdata <= word;
      irq_o <= |(act & ~sel);
      fiq_o <= |(act & sel);
    end
  end

endmodule

// File: rtl/dpic_regbank.sv
module dpic_regbank
  import dpic_pkg::*;
#(
  parameter int                NLINES    = 51,
  parameter int                ADDR_W    = 8,
  parameter int                NEW_BASE  = 128,
  parameter int                EVT_LO    = 47,
  parameter int                EVT_W     = 4,
  parameter logic [NLINES-1:0] SENSE_RST = NLINES'(64'h1F07FFF8FFFF),
  parameter logic [NLINES-1:0] BOTH_RST  = NLINES'(64'h00F800070000),
  parameter logic [NLINES-1:0] EVT_RST   = NLINES'(64'h5F07FFF8FFFF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              resp_valid,
  input  logic [NLINES-1:0] cap_level,
  input  logic [NLINES-1:0] cap_set,
  output logic [NLINES-1:0] cfg_sense,
  output logic [NLINES-1:0] cfg_both,
  output logic [NLINES-1:0] cfg_event,
  output logic              irq_o,
  output logic              fiq_o
);

  dpic_dec_t         dec;
  logic              wr_en, rd_en;
  logic [NLINES-1:0] raw_v, en_v, sel_v, evt_v;

  assign wr_en     = bus_valid & bus_write;
  assign rd_en     = bus_valid & ~bus_write;
  assign cfg_sense = SENSE_RST;
  assign cfg_both  = BOTH_RST;
  assign cfg_event = evt_v;

  dpic_decode #(.ADDR_W(ADDR_W), .NEW_BASE(NEW_BASE)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  dpic_state #(.NLINES(NLINES), .EVT_LO(EVT_LO), .EVT_W(EVT_W), .EVT_RST(EVT_RST)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .dec       (dec),
    .wdata     (bus_wdata),
    .sense     (SENSE_RST),
    .cap_level (cap_level),
    .cap_set   (cap_set),
    .raw_q     (raw_v),
    .en_q      (en_v),
    .sel_q     (sel_v),
    .evt_q     (evt_v)
  );

  dpic_out #(.NLINES(NLINES)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .dec        (dec),
    .raw        (raw_v),
    .en         (en_v),
    .sel        (sel_v),
    .sense      (SENSE_RST),
    .both       (BOTH_RST),
    .evt        (evt_v),
    .rdata      (bus_rdata),
    .resp_valid (resp_valid),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o)
  );

endmodule

// File: rtl/dpic_regbank_chk.sv
module dpic_regbank_chk #(
  parameter int NLINES   = 51,
  parameter int ADDR_W   = 8,
  parameter int NEW_BASE = 128,
  parameter int EVT_LO   = 47
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              resp_valid,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NLINES-1:0] en_v,
  input logic [NLINES-1:0] evt_v
);

  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(NEW_BASE + 'h20);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(NEW_BASE + 'h28);

  // R11: one response the cycle after each read
  p_resp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> resp_valid);
  p_resp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !resp_valid);

  // R8: write-only address reads back zero
  p_wo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == A_ENCLR) |=> (bus_rdata == 32'h0));

  // R3: set and clear act on the written bits
  p_enset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == A_ENSET)
      |=> ((en_v[31:0] & $past(bus_wdata)) == $past(bus_wdata)));
  p_enclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == A_ENCLR)
      |=> ((en_v[31:0] & $past(bus_wdata)) == 32'h0));

  // R7: event lines below the writable field never change
  p_evt_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_v[EVT_LO-1:0] == $past(evt_v[EVT_LO-1:0])));

  // R9: nothing enabled means both outputs low a cycle later
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_v == '0) |=> (!irq_o && !fiq_o));

endmodule

bind dpic_regbank dpic_regbank_chk #(
  .NLINES(NLINES), .ADDR_W(ADDR_W), .NEW_BASE(NEW_BASE), .EVT_LO(EVT_LO)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .resp_valid (resp_valid),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .en_v       (en_v),
  .evt_v      (evt_v)
);

// File: tb/tb_dpic_regbank.sv
module tb_dpic_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        resp_valid;
  logic [50:0] cap_level = '0, cap_set = '0;
  logic [50:0] cfg_sense, cfg_both, cfg_event;
  logic        irq_o, fiq_o;

  int nchecks = 0, nerrors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dpic_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .resp_valid(resp_valid), .cap_level(cap_level), .cap_set(cap_set),
    .cfg_sense(cfg_sense), .cfg_both(cfg_both), .cfg_event(cfg_event),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data on the falling edge after the response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected response", 64'd1, 64'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {32'h0, bus_rdata}, {32'h0, e});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R11 no response to write", {63'h0, resp_valid}, 64'd0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic outs(input string tag, input logic ei, input logic ef);
    chk({tag, " irq"}, {63'h0, irq_o}, {63'h0, ei});
    chk({tag, " fiq"}, {63'h0, fiq_o}, {63'h0, ef});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    outs("R1 reset", 1'b0, 1'b0);
    chk("R1 resp idle", {63'h0, resp_valid}, 64'd0);
    chk("R1 cfg_sense", {13'h0, cfg_sense}, 64'h1F07FFF8FFFF);
    chk("R1 cfg_both", {13'h0, cfg_both}, 64'h00F800070000);
    rd(8'hC0, 32'hFFF8FFFF, "R1 sense lo");
    rd(8'hC4, 32'h00001F07, "R1 sense hi");
    rd(8'hC8, 32'h00070000, "R1 both lo");
    rd(8'hCC, 32'h000000F8, "R1 both hi");
    rd(8'hD0, 32'hFFF8FFFF, "R1 event lo");
    rd(8'hD4, 32'h00005F07, "R1 event hi");
    rd(8'hA0, 32'h0, "R1 enable");
    rd(8'h98, 32'h0, "R1 select");
    rd(8'h24, 32'hFFF8FFFF, "R2 legacy sense");

    // R2: high word masking
    wr(8'hA4, 32'hFFFFFFFF);
    rd(8'hA4, 32'h0007FFFF, "R2 high word masked");
    rd(8'hA0, 32'h0, "R2 low untouched by high write");
    wr(8'hAC, 32'hFFFFFFFF);
    rd(8'hA4, 32'h0, "R3 high clear");

    // R3: set and clear, both windows
    wr(8'hA0, 32'h000000F0);
    wr(8'h10, 32'h0000000F);
    rd(8'hA0, 32'h000000FF, "R3 set ORs");
    wr(8'h14, 32'h0000003C);
    rd(8'hA0, 32'h000000C3, "R3 clear");
    rd(8'h10, 32'h000000C3, "R2 legacy enable read");

    // R4: half replacement of routing
    wr(8'h9C, 32'h00012345);
    wr(8'h98, 32'hAAAA5555);
    rd(8'h9C, 32'h00012345, "R4 high kept");
    rd(8'h98, 32'hAAAA5555, "R4 low");
    wr(8'h0C, 32'h00000001);
    rd(8'h98, 32'h00000001, "R4 legacy low replace");
    rd(8'h9C, 32'h00012345, "R4 high kept after legacy");
    wr(8'h9C, 32'h0);

    // R10/R9: level line 0 routed to fast output
    cap_level[0] = 1'b1;
    @(negedge clk);
    outs("R9 latency", 1'b0, 1'b0);
    @(negedge clk);
    outs("R9 level to fast", 1'b0, 1'b1);
    wr(8'hA0, 32'h00010000);
    cap_set[16] = 1'b1;
    cap_set[1]  = 1'b1;   // level line: pulse has no effect
    @(negedge clk);
    cap_set = '0;
    @(negedge clk);
    outs("R9 edge to normal", 1'b1, 1'b1);
    rd(8'h90, 32'h00010001, "R10 pending");
    rd(8'h80, 32'h00010000, "R5 normal status");
    rd(8'h88, 32'h00000001, "R5 fast status");
    rd(8'hE0, 32'h00010000, "R5 edge status");
    rd(8'h00, 32'h00010000, "R2 legacy normal status");
    rd(8'h04, 32'h00000001, "R2 legacy fast status");
    rd(8'h08, 32'h00010001, "R2 legacy pending");

    // R6: edge clear spares level lines
    wr(8'hD8, 32'hFFFFFFFF);
    outs("R9 still old", 1'b1, 1'b1);
    @(negedge clk);
    outs("R6 after clear", 1'b0, 1'b1);
    rd(8'h90, 32'h00000001, "R6 level kept");
    cap_level[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    outs("R10 level drop", 1'b0, 1'b0);

    // R10: pulse wins over simultaneous clear
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'hD8; bus_wdata = 32'h00020000;
    cap_set[17] = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; cap_set = '0;
    rd(8'h90, 32'h00020000, "R10 set wins");
    wr(8'h38, 32'h00020000);
    rd(8'h90, 32'h0, "R6 legacy edge clear");

    // R6/R2: high-word edge line 45
    cap_set[45] = 1'b1;
    @(negedge clk);
    cap_set = '0;
    rd(8'h94, 32'h00002000, "R2 pending high");
    wr(8'hDC, 32'h00002000);
    rd(8'h94, 32'h0, "R6 high edge clear");

    // R7: event field
    wr(8'hD4, 32'hFFFFFFFF);
    rd(8'hD4, 32'h0007DF07, "R7 high bits 18:15");
    chk("R7 cfg_event field", {60'h0, cfg_event[50:47]}, 64'hF);
    wr(8'hD0, 32'h0);
    rd(8'hD0, 32'hFFF8FFFF, "R7 low write ignored");
    wr(8'h2C, 32'h0);
    rd(8'h2C, 32'hFFF8FFFF, "R7 legacy write ignored");
    wr(8'hD4, 32'h0);
    rd(8'hD4, 32'h00005F07, "R7 field cleared");

    // R8: write-only, software and unmapped
    rd(8'hA8, 32'h0, "R8 enable clear read");
    rd(8'hB8, 32'h0, "R8 sw clear read");
    rd(8'hD8, 32'h0, "R8 edge clear read");
    rd(8'h14, 32'h0, "R8 legacy enable clear read");
    wr(8'hB0, 32'hFFFFFFFF);
    rd(8'hB0, 32'h0, "R8 sw read");
    wr(8'h90, 32'hFFFFFFFF);
    rd(8'h90, 32'h0, "R8 pending read-only");
    wr(8'hC0, 32'h0);
    rd(8'hC0, 32'hFFF8FFFF, "R8 sense read-only");
    rd(8'h40, 32'h0, "R8 unmapped legacy");
    rd(8'hF0, 32'h0, "R8 unmapped new");
    rd(8'hA1, 32'h0, "R8 misaligned");
    wr(8'h40, 32'hFFFFFFFF);
    wr(8'hA1, 32'hFFFFFFFF);
    rd(8'hA0, 32'h000100C3, "R8 enable untouched");
    outs("R8 outputs unchanged", 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    chk("R11 all responses seen", exp_q.size(), 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

endmodule